// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one burst request into the column address of every beat of an SDRAM burst. A one-cycle start strobe captures a 9-bit starting column, a 3-bit burst length code and an ordering bit. From the next cycle on, the block presents one column per clock, together with a beat-valid flag and a flag that marks the final beat. A memory controller uses these outputs to fill the column field of each read or write beat, or to index its data buffers.

Fixed bursts of 2, 4 or 8 beats stay inside an aligned block of that size. The column bits above the block never change, and the low bits advance in either linear-wrap order or XOR order. A full-page burst steps through the whole 512-column row, wrapping from 511 to 0. It never ends by itself, so a terminate input is needed to stop it. The terminate input also cuts a fixed burst short.

If a start arrives while a burst is running, the running burst is dropped and the new one takes over. Unsupported length settings produce a flagged single-beat access.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, and whenever no burst is running, `beat_vld_o`, `last_o` and `cfg_err_o` are all low.
- R2: A start sampled high at a clock edge makes the first beat appear right after that edge, with `col_o` equal to the captured start column. After that, one beat is presented per clock.
- R3: The length code on `bl_code_i` gives the beat count: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4 and 3'b011 gives 8. `last_o` is high on the final beat only, and `beat_vld_o` is low in the cycle after it.
- R4: For lengths 2, 4 and 8, the column bits above the low 1, 2 or 3 bits keep the start value for the whole burst, so every column stays in the aligned block.
- R5: With `itlv_i` = 0, the low bits of beat k equal (start low bits + k) modulo the burst length. For example, start 5 at length 8 gives 5,6,7,0,1,2,3,4.
- R6: With `itlv_i` = 1, the low bits of beat k equal the start low bits XOR k. For example, start 5 at length 8 gives 5,4,7,6,1,0,3,2.
- R7: At length 1, `itlv_i` has no effect: the single beat shows the start column with `last_o` high.
- R8: Code 3'b111 with `itlv_i` = 0 is a full-page burst. Beat k shows (start + k) modulo 512, `last_o` stays low, and the burst runs until it is terminated or preempted.
- R9: If `term_i` is high at an edge while a burst runs, the beat shown before that edge is the last one, and `beat_vld_o` is low after the edge. If `term_i` is high while the block is idle, it has no effect.
- R10: The codes 3'b100, 3'b101 and 3'b110, and code 3'b111 with `itlv_i` = 1, produce one beat at the start column, with `cfg_err_o` and `last_o` both high.
- R11: A start sampled during a running burst drops that burst. Beat 0 of the new burst appears right after that edge. If start and terminate are sampled at the same edge, the start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Burst start strobe |
| col_i | input | 9 | Starting column |
| bl_code_i | input | 3 | Burst length code |
| itlv_i | input | 1 | Ordering: 0 linear wrap, 1 XOR order |
| term_i | input | 1 | Terminate the running burst |
| col_o | output | 9 | Column of the current beat |
| beat_vld_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Final beat of a fixed-length burst |
| cfg_err_o | output | 1 | Unsupported length setting; single-beat access |

## Verification
A corrupted beat counter or a wrong held mask shows on `col_o` within one beat. It appears either as an address outside the aligned block or as a step in the wrong order. A lost or wrong active flag shows as a missing beat, an extra beat, or a misplaced `last_o` in the cycle where the burst should end. Every beat goes into a scoreboard in order, so the first wrong column or flag is reported in the cycle it appears. A burst that runs too long or too short is found because the scoreboard queue ends up with items left over or runs empty.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
    localparam int COL_W     = 9;
    localparam int CODE_W    = 3;
    localparam int MAX_LOG2  = 3;
    localparam logic [CODE_W-1:0] CODE_PAGE = 3'b111;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
    import bcg_pkg::*;
#(
    parameter int COL_W_P  = COL_W,
    parameter int MAX_LG_P = MAX_LOG2
) (
    input  logic [CODE_W-1:0]  code_i,
    input  logic               itlv_i,
    output logic [COL_W_P-1:0] mask_o,
    output logic               page_o,
    output logic               err_o
);
    localparam int LG_W = $clog2(MAX_LG_P + 1);

    logic [LG_W-1:0] lg;
    logic            fixed_ok;

    always_comb begin
        fixed_ok = (32'(code_i) <= MAX_LG_P);
        lg       = fixed_ok ? LG_W'(code_i) : '0;
        page_o   = (code_i == CODE_PAGE) && !itlv_i;
        err_o    = !fixed_ok && !page_o;
        if (page_o) begin
            mask_o = '1;
        end else begin
            mask_o = COL_W_P'((1 << lg) - 1);
        end
    end
endmodule

// File: rtl/bcg_col_order.sv
module bcg_col_order #(
    parameter int COL_W_P = 9
) (
    input  logic [COL_W_P-1:0] base_i,
    input  logic [COL_W_P-1:0] cnt_i,
    input  logic [COL_W_P-1:0] mask_i,
    input  logic               itlv_i,
    output logic [COL_W_P-1:0] col_o
);
    logic [COL_W_P-1:0] lin;
    logic [COL_W_P-1:0] xrd;

    genvar b;
    generate
        for (b = 0; b < COL_W_P; b++) begin : g_bit
            assign xrd[b] = base_i[b] ^ cnt_i[b];
        end
    endgenerate

    always_comb begin
        lin   = base_i + cnt_i;
        col_o = (base_i & ~mask_i) | (mask_i & (itlv_i ? xrd : lin));
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int COL_W_P = COL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [COL_W_P-1:0]  col_i,
    input  logic [CODE_W-1:0]   bl_code_i,
    input  logic                itlv_i,
    input  logic                term_i,
    output logic [COL_W_P-1:0]  col_o,
    output logic                beat_vld_o,
    output logic                last_o,
    output logic                cfg_err_o
);
    typedef struct packed {
        logic               active;
        logic [COL_W_P-1:0] base;
        logic [COL_W_P-1:0] cnt;
        logic [COL_W_P-1:0] mask;
        logic               page;
        logic               itlv;
        logic               err;
    } burst_st_t;

    burst_st_t st_d, st_q;

    logic [COL_W_P-1:0] dec_mask;
    logic               dec_page;
    logic               dec_err;
    logic               at_end;

    bcg_len_decode #(.COL_W_P(COL_W_P), .MAX_LG_P(MAX_LOG2)) u_dec (
        .code_i (bl_code_i),
        .itlv_i (itlv_i),
        .mask_o (dec_mask),
        .page_o (dec_page),
        .err_o  (dec_err)
    );

    bcg_col_order #(.COL_W_P(COL_W_P)) u_ord (
        .base_i (st_q.base),
        .cnt_i  (st_q.cnt),
        .mask_i (st_q.mask),
        .itlv_i (st_q.itlv),
        .col_o  (col_o)
    );

    always_comb begin
        at_end = st_q.active && !st_q.page && (st_q.cnt == st_q.mask);
        st_d   = st_q;
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.base   = col_i;
            st_d.cnt    = '0;
            st_d.mask   = dec_mask;
            st_d.page   = dec_page;
            st_d.itlv   = itlv_i && !dec_err;
            st_d.err    = dec_err;
        end else if (st_q.active) begin
            if (term_i || at_end) begin
                st_d.active = 1'b0;
                st_d.err    = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign beat_vld_o = st_q.active;
    assign last_o     = at_end;
    assign cfg_err_o  = st_q.active && st_q.err;
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
    parameter int COL_W_P = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [COL_W_P-1:0] col_i,
    input logic               term_i,
    input logic [COL_W_P-1:0] col_o,
    input logic               beat_vld_o,
    input logic               last_o,
    input logic               cfg_err_o
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_vld_o |-> (!last_o && !cfg_err_o));

    a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (beat_vld_o && col_o == $past(col_i)));

    a_r3_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_o && last_o && !start_i) |=> !beat_vld_o);

    a_r9_term_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_o && term_i && !start_i) |=> !beat_vld_o);

    a_r9_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat_vld_o && !start_i) |=> !beat_vld_o);

    a_r10_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> (beat_vld_o && last_o));
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W_P(COL_W_P)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .col_i      (col_i),
    .term_i     (term_i),
    .col_o      (col_o),
    .beat_vld_o (beat_vld_o),
    .last_o     (last_o),
    .cfg_err_o  (cfg_err_o)
);

// File: tb/sim_burst_col_gen.sv
module sim_burst_col_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i;
    logic [8:0] col_i;
    logic [2:0] bl_code_i;
    logic       itlv_i;
    logic       term_i;
    logic [8:0] col_o;
    logic       beat_vld_o;
    logic       last_o;
    logic       cfg_err_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [8:0] col;
        logic       last;
        logic       err;
        int         req;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_gen u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .col_i      (col_i),
        .bl_code_i  (bl_code_i),
        .itlv_i     (itlv_i),
        .term_i     (term_i),
        .col_o      (col_o),
        .beat_vld_o (beat_vld_o),
        .last_o     (last_o),
        .cfg_err_o  (cfg_err_o)
    );

    function automatic int blen(input logic [2:0] code, input logic typ);
        case (code)
            3'b000:  return 1;
            3'b001:  return 2;
            3'b010:  return 4;
            3'b011:  return 8;
            3'b111:  return typ ? 1 : 512;
            default: return 1;
        endcase
    endfunction

    function automatic logic is_err(input logic [2:0] code, input logic typ);
        return (code inside {3'b100, 3'b101, 3'b110}) || (code == 3'b111 && typ);
    endfunction

    function automatic logic [8:0] ref_col(input logic [8:0] s, input logic [2:0] code,
                                           input logic typ, input int k);
        int size;
        int off;
        int base;
        int idx;
        size = blen(code, typ);
        if (size == 512) return 9'((int'(s) + k) % 512);
        off  = int'(s) % size;
        base = int'(s) - off;
        idx  = (typ && size > 1) ? (off ^ k) : ((off + k) % size);
        return 9'(base + idx);
    endfunction

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // driver: queue expected beats, pulse start, optionally end with terminate
    task automatic issue(input logic [8:0] c, input logic [2:0] code, input logic typ,
                         input int nb, input bit end_term, input bit with_term, input int req);
        int size;
        size = blen(code, typ);
        for (int k = 0; k < nb; k++) begin
            exp_t e;
            e.col  = ref_col(c, code, typ, k);
            e.last = (size != 512) && (k == size - 1);
            e.err  = is_err(code, typ);
            e.req  = req;
            sb.push_back(e);
        end
        start_i   = 1'b1;
        col_i     = c;
        bl_code_i = code;
        itlv_i    = typ;
        term_i    = with_term;
        @(posedge clk); #1;
        start_i = 1'b0;
        term_i  = 1'b0;
        col_i   = '0;
        for (int k = 1; k < nb; k++) begin
            @(posedge clk); #1;
        end
        if (end_term) begin
            term_i = 1'b1;
            @(posedge clk); #1;
            term_i = 1'b0;
        end
    endtask

    task automatic idle_check(input int n, input int req);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
        tests++;
        if (beat_vld_o !== 1'b0 || sb.size() != 0) begin
            fails++;
            $display("FAIL R%0d idle: beat_vld=%b exp 0, pending=%0d exp 0",
                     req, beat_vld_o, sb.size());
            sb.delete();
        end
    endtask

    // monitor: compare each presented beat with the scoreboard head
    always @(negedge clk) begin
        if (rst_n === 1'b1 && beat_vld_o === 1'b1) begin
            tests++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R3 extra beat: col=%0d, expected no beat", col_o);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (col_o !== e.col || last_o !== e.last || cfg_err_o !== e.err) begin
                    fails++;
                    $display("FAIL R%0d beat: col=%0d exp %0d last=%b exp %b err=%b exp %b",
                             e.req, col_o, e.col, last_o, e.last, cfg_err_o, e.err);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; col_i = '0; bl_code_i = '0; itlv_i = 1'b0; term_i = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        tests++;
        if (beat_vld_o !== 1'b0 || last_o !== 1'b0 || cfg_err_o !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: vld=%b last=%b err=%b, expected 0 0 0",
                     beat_vld_o, last_o, cfg_err_o);
        end
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R5 R2: linear order, length 8, start 5
        issue(9'd5, 3'b011, 1'b0, 8, 0, 0, 5);
        idle_check(2, 3);
        // R6: XOR order, length 8, start 5
        issue(9'd5, 3'b011, 1'b1, 8, 0, 0, 6);
        idle_check(2, 3);
        // R4 R5: length 4 inside block at 420
        issue(9'd422, 3'b010, 1'b0, 4, 0, 0, 4);
        idle_check(1, 3);
        // R4 R6: length 4 XOR at 499
        issue(9'd499, 3'b010, 1'b1, 4, 0, 0, 4);
        idle_check(1, 3);
        // R3: length 2 both orders
        issue(9'd3, 3'b001, 1'b0, 2, 0, 0, 3);
        issue(9'd2, 3'b001, 1'b1, 2, 0, 0, 3);
        idle_check(1, 3);
        // R7: length 1 ignores order
        issue(9'd300, 3'b000, 1'b1, 1, 0, 0, 7);
        issue(9'd301, 3'b000, 1'b0, 1, 0, 0, 7);
        idle_check(1, 7);
        // R8: full page wraps 511 -> 0, stopped by terminate
        issue(9'd510, 3'b111, 1'b0, 5, 1, 0, 8);
        idle_check(2, 9);
        // R8: full page past a whole row
        issue(9'd7, 3'b111, 1'b0, 520, 1, 0, 8);
        idle_check(2, 9);
        // R9: terminate a fixed burst after 3 beats
        issue(9'd16, 3'b011, 1'b0, 3, 1, 0, 9);
        idle_check(2, 9);
        // R9: terminate while idle has no effect
        term_i = 1'b1;
        @(posedge clk); #1;
        term_i = 1'b0;
        idle_check(2, 9);
        // R10: reserved codes and page with XOR order
        issue(9'd77, 3'b101, 1'b0, 1, 0, 0, 10);
        idle_check(1, 10);
        issue(9'd200, 3'b111, 1'b1, 1, 0, 0, 10);
        idle_check(1, 10);
        issue(9'd33, 3'b100, 1'b1, 1, 0, 0, 10);
        issue(9'd34, 3'b110, 1'b0, 1, 0, 0, 10);
        idle_check(1, 10);
        // R11: preemption by a new start
        issue(9'd40, 3'b011, 1'b0, 3, 0, 0, 11);
        issue(9'd101, 3'b010, 1'b1, 4, 0, 0, 11);
        idle_check(2, 11);
        // R11: start wins over a simultaneous terminate
        issue(9'd8, 3'b011, 1'b0, 2, 0, 0, 11);
        issue(9'd9, 3'b001, 1'b0, 2, 0, 1, 11);
        idle_check(2, 11);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule